// File: doc/BRIEF.md
# Macroblock Inter/Intra Mode Decision Unit

This unit makes the per-macroblock coding-mode decision of a video encoder. For each macroblock it receives three ready-made 14-bit measures from the surrounding pipeline: the mean absolute error of the best motion-search match, the same error at zero displacement, and a simplified variance of the current macroblock. From these, plus an 8-bit host threshold and a set of host control levels, it decides two things. The first is whether motion compensation is worth applying. The second is whether the macroblock is coded inter or intra. It also reports whether the intra result came from its own periodic refresh, and whether the macroblock was fixed or its frame skipped.

A motion-compensated match is accepted only when the zero-displacement error exceeds 9/8 of the best-match error. The error that wins then feeds a two-stage inter test. Inter coding is taken outright when the top eight bits of that error fall below the threshold. Above the threshold, inter is taken only when the variance is at least as large as the error. An internal modulo-61 refresh counter forces every 61st counted macroblock to intra. On top of this sits a fixed override priority: skip frame, then fix macroblock, then fast update, then host force, then refresh, then the computed result. Fast update and skip are frame-scoped requests that are latched on the frame-start pulse.

The controller has three states. In GATHER it captures each measure on its own strobe. GATHER moves to EVAL once all three have been captured. EVAL registers the decision and moves to EMIT. EMIT presents the one-cycle valid strobe and returns to GATHER.

Top module: `mbd_mode_decider`

## Requirements
- R1: `mc_used` is 1 only when 8 × `zero_err` is strictly greater than 9 × `best_err`, motion compensation is not disabled, the result is inter, and the macroblock is neither fixed nor skipped. A point exactly on the 9/8 line does not select motion compensation.
- R2: The error used by the inter test is `best_err` when the 9/8 rule accepts motion compensation, and `zero_err` otherwise.
- R3: If the top 8 bits (bits 13:6) of the error in use are not below the threshold, the computed mode is inter exactly when `var_val` >= that error, and intra otherwise.
- R4: When bits 13:6 of the error in use are below the threshold, the computed mode is inter. The threshold resets to 3, and a pulse on `thr_load` replaces it with `thr_data`.
- R5: A refresh counter advances once per counted decision. It starts from 0 after reset. The 61st counted decision, and every 61st one after it, is intra with `forced_intra` = 1.
- R6: The refresh counter holds its value while `refresh_off` is 1, while `fix_mb` is 1, or while skip is active. A decision made under any of these neither counts nor is refresh-forced.
- R7: With `ovr_en` = 1, `ovr_intra` = 1 forces intra and `ovr_intra` = 0 forces inter. A forced inter also suppresses a refresh hit, so `forced_intra` = 0.
- R8: `fast_upd_req` is latched on a `frame_start` pulse. While the latched value is 1, every decision is intra. Clearing the request has no effect until the next `frame_start`.
- R9: `skip_req` is latched on `frame_start` and has top priority. While skip is active, each decision reports `skipped_out` = 1, `fixed_out` = 0, `mc_used` = 0, `inter_mode` = 1 and `forced_intra` = 0.
- R10: When skip is not active, `fix_mb` = 1 gives `fixed_out` = 1, `mc_used` = 0, `inter_mode` = 1 and `forced_intra` = 0, and this overrides fast update, host force and refresh.
- R11: `mc_disable` = 1 makes `mc_used` 0, and `zero_err` is then the error in use.
- R12: Each of the three measures is captured by its own strobe, but only in GATHER. Strobes in EVAL or EMIT are ignored. `dec_valid` rises two clock edges after the edge that captures the last measure and stays high for exactly one cycle. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| best_err | input | 14 | Best-match mean absolute error |
| best_vld | input | 1 | Capture strobe for best_err |
| zero_err | input | 14 | Zero-displacement mean absolute error |
| zero_vld | input | 1 | Capture strobe for zero_err |
| var_val | input | 14 | Simplified macroblock variance |
| var_vld | input | 1 | Capture strobe for var_val |
| thr_load | input | 1 | Load pulse for the threshold |
| thr_data | input | 8 | New threshold value |
| mc_disable | input | 1 | Setup level: motion compensation off |
| refresh_off | input | 1 | Host level: periodic refresh disabled |
| fix_mb | input | 1 | Host level: fix current macroblock |
| ovr_en | input | 1 | Host level: override mode decision |
| ovr_intra | input | 1 | Override direction, 1 = intra, 0 = inter |
| fast_upd_req | input | 1 | Fast-update request, latched at frame start |
| skip_req | input | 1 | Skip-frame request, latched at frame start |
| frame_start | input | 1 | New-frame pulse |
| dec_valid | output | 1 | One-cycle decision strobe |
| mc_used | output | 1 | Motion compensation applied |
| inter_mode | output | 1 | 1 = inter, 0 = intra |
| forced_intra | output | 1 | Intra forced by the refresh counter |
| fixed_out | output | 1 | Macroblock fixed |
| skipped_out | output | 1 | Frame skipped |

## Verification
The hardest situation to reach from the ports is a refresh hit that coincides with a host override, a fix, or a paused counter. The hit only happens on one decision in 61, and only if the counter was not paused along the way. The bench tracks the counter in its own model. It then runs plain decisions until the model sits just before a hit, and at that point applies force-inter, force-intra, `refresh_off` or `fix_mb`. Random runs add near-slope error pairs, so that the 9/8 boundary and the threshold boundary are crossed often.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        S_GATHER = 2'd0,
        S_EVAL   = 2'd1,
        S_EMIT   = 2'd2
    } mbd_state_e;

    typedef struct packed {
        logic mc;
        logic inter;
        logic forced;
        logic fixed;
        logic skipped;
    } mbd_dec_t;

endpackage

// File: rtl/mbd_mc_select.sv
module mbd_mc_select #(
    parameter int ERR_W  = 14,
    parameter int MC_NUM = 9,
    parameter int MC_DEN = 8
) (
    input  logic [ERR_W-1:0] best_err,
    input  logic [ERR_W-1:0] zero_err,
    input  logic             mc_disable,
    output logic             mc_ok,
    output logic [ERR_W-1:0] err_use
);
    localparam int PW = ERR_W + $clog2(MC_NUM + MC_DEN + 1) + 1;

    logic [PW-1:0] zero_scaled;
    logic [PW-1:0] best_scaled;

    // Slope test without division: zero*DEN > best*NUM
    always_comb begin
        zero_scaled = PW'(zero_err) * PW'(MC_DEN);
        best_scaled = PW'(best_err) * PW'(MC_NUM);
        mc_ok       = !mc_disable && (zero_scaled > best_scaled);
        err_use     = mc_ok ? best_err : zero_err;
    end

endmodule

// File: rtl/mbd_inter_test.sv
module mbd_inter_test #(
    parameter int ERR_W = 14,
    parameter int THR_W = 8
) (
    input  logic [ERR_W-1:0] err_use,
    input  logic [ERR_W-1:0] var_val,
    input  logic [THR_W-1:0] thr,
    output logic             inter_ok
);
    localparam int SH = ERR_W - THR_W;

    logic [THR_W-1:0] err_hi;
    logic             below_thr;

    always_comb begin
        err_hi    = err_use[ERR_W-1:SH];
        below_thr = err_hi < thr;
        inter_ok  = below_thr || (var_val >= err_use);
    end

endmodule

// File: rtl/mbd_refresh_ctr.sv
module mbd_refresh_ctr #(
    parameter int PERIOD = 61
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic enable,
    output logic hit
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign hit = enable && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (advance && enable) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !enable) |=> (cnt == $past(cnt))); // R6

endmodule

// File: rtl/mbd_mode_decider.sv
module mbd_mode_decider
    import mbd_pkg::*;
#(
    parameter int ERR_W          = 14,
    parameter int THR_W          = 8,
    parameter int THR_RESET      = 3,
    parameter int REFRESH_PERIOD = 61,
    parameter int MC_NUM         = 9,
    parameter int MC_DEN         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] best_err,
    input  logic             best_vld,
    input  logic [ERR_W-1:0] zero_err,
    input  logic             zero_vld,
    input  logic [ERR_W-1:0] var_val,
    input  logic             var_vld,
    input  logic             thr_load,
    input  logic [THR_W-1:0] thr_data,
    input  logic             mc_disable,
    input  logic             refresh_off,
    input  logic             fix_mb,
    input  logic             ovr_en,
    input  logic             ovr_intra,
    input  logic             fast_upd_req,
    input  logic             skip_req,
    input  logic             frame_start,
    output logic             dec_valid,
    output logic             mc_used,
    output logic             inter_mode,
    output logic             forced_intra,
    output logic             fixed_out,
    output logic             skipped_out
);
    localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_RESET);

    mbd_state_e       state, state_nx;
    logic [ERR_W-1:0] best_q, zero_q, var_q;
    logic             have_best, have_zero, have_var;
    logic [THR_W-1:0] thr_q;
    logic             fu_act, skip_act;
    logic             mc_ok, inter_ok, ref_hit, ref_en;
    logic [ERR_W-1:0] err_use;
    mbd_dec_t         dec_nx, dec_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_GATHER;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_GATHER: if (have_best && have_zero && have_var) state_nx = S_EVAL;
            S_EVAL:   state_nx = S_EMIT;
            S_EMIT:   state_nx = S_GATHER;
            default:  state_nx = S_GATHER;
        endcase
    end

    // ---------------- measure capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_q <= '0; zero_q <= '0; var_q <= '0;
            have_best <= 1'b0; have_zero <= 1'b0; have_var <= 1'b0;
        end else if (state == S_GATHER) begin
            if (best_vld) begin best_q <= best_err; have_best <= 1'b1; end
            if (zero_vld) begin zero_q <= zero_err; have_zero <= 1'b1; end
            if (var_vld)  begin var_q  <= var_val;  have_var  <= 1'b1; end
        end else if (state == S_EVAL) begin
            have_best <= 1'b0; have_zero <= 1'b0; have_var <= 1'b0;
        end
    end

    // ---------------- host threshold and frame-scoped latches ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q    <= THR_INIT;
            fu_act   <= 1'b0;
            skip_act <= 1'b0;
        end else begin
            if (thr_load) thr_q <= thr_data;
            if (frame_start) begin
                fu_act   <= fast_upd_req;
                skip_act <= skip_req;
            end
        end
    end

    // ---------------- datapath submodules ----------------
    mbd_mc_select #(.ERR_W(ERR_W), .MC_NUM(MC_NUM), .MC_DEN(MC_DEN)) u_mc (
        .best_err  (best_q),
        .zero_err  (zero_q),
        .mc_disable(mc_disable),
        .mc_ok     (mc_ok),
        .err_use   (err_use)
    );

    mbd_inter_test #(.ERR_W(ERR_W), .THR_W(THR_W)) u_test (
        .err_use (err_use),
        .var_val (var_q),
        .thr     (thr_q),
        .inter_ok(inter_ok)
    );

    assign ref_en = !skip_act && !fix_mb && !refresh_off;

    mbd_refresh_ctr #(.PERIOD(REFRESH_PERIOD)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(state == S_EVAL),
        .enable (ref_en),
        .hit    (ref_hit)
    );

    // ---------------- priority resolution ----------------
    always_comb begin
        dec_nx = '0;
        if (skip_act) begin
            dec_nx.skipped = 1'b1;
            dec_nx.inter   = 1'b1;
        end else if (fix_mb) begin
            dec_nx.fixed = 1'b1;
            dec_nx.inter = 1'b1;
        end else begin
            dec_nx.forced = ref_hit && !(ovr_en && !ovr_intra);
            if (fu_act)       dec_nx.inter = 1'b0;
            else if (ovr_en)  dec_nx.inter = !ovr_intra;
            else if (ref_hit) dec_nx.inter = 1'b0;
            else              dec_nx.inter = inter_ok;
            dec_nx.mc = mc_ok && dec_nx.inter;
        end
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q     <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= (state == S_EVAL);
            if (state == S_EVAL) dec_q <= dec_nx;
        end
    end

    assign mc_used      = dec_q.mc;
    assign inter_mode   = dec_q.inter;
    assign forced_intra = dec_q.forced;
    assign fixed_out    = dec_q.fixed;
    assign skipped_out  = dec_q.skipped;

    // ---------------- assertions ----------------
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid); // R12
    AST_VALID_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVAL) |=> dec_valid); // R12
    AST_MC_INTER: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && mc_used) |-> inter_mode); // R1
    AST_FORCED_INTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && forced_intra) |-> !inter_mode); // R5
    AST_SKIP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && skipped_out) |-> (!fixed_out && !mc_used && !forced_intra)); // R9
    AST_FIX_NO_MC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && fixed_out) |-> (!mc_used && !forced_intra && inter_mode)); // R10
    AST_MC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_EVAL) && mc_disable) |=> !mc_used); // R11
    AST_FU_INTRA: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_EVAL) && fu_act && !skip_act && !fix_mb) |=> !inter_mode); // R8

endmodule

// File: tb/mbd_mode_decider_bench.sv
module mbd_mode_decider_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] best_err = '0, zero_err = '0, var_val = '0;
    logic        best_vld = 0, zero_vld = 0, var_vld = 0;
    logic        thr_load = 0;
    logic [7:0]  thr_data = '0;
    logic        mc_disable = 0, refresh_off = 0, fix_mb = 0, ovr_en = 0, ovr_intra = 0;
    logic        fast_upd_req = 0, skip_req = 0, frame_start = 0;
    logic        dec_valid, mc_used, inter_mode, forced_intra, fixed_out, skipped_out;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    int   m_cnt = 0;
    int   m_thr = 3;
    logic m_fu = 0, m_skip = 0;

    always #5 clk = ~clk;

    mbd_mode_decider u_mbd_mode_decider (
        .clk(clk), .rst_n(rst_n),
        .best_err(best_err), .best_vld(best_vld),
        .zero_err(zero_err), .zero_vld(zero_vld),
        .var_val(var_val), .var_vld(var_vld),
        .thr_load(thr_load), .thr_data(thr_data),
        .mc_disable(mc_disable), .refresh_off(refresh_off), .fix_mb(fix_mb),
        .ovr_en(ovr_en), .ovr_intra(ovr_intra),
        .fast_upd_req(fast_upd_req), .skip_req(skip_req), .frame_start(frame_start),
        .dec_valid(dec_valid), .mc_used(mc_used), .inter_mode(inter_mode),
        .forced_intra(forced_intra), .fixed_out(fixed_out), .skipped_out(skipped_out)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // expected decision from the requirements; advances model counter
    task automatic model(input logic [13:0] b, z, v,
                         output logic e_mc, e_inter, e_forced, e_fix, e_skip);
        logic mc, comp, en, hit;
        logic [13:0] e;
        e_mc = 0; e_inter = 0; e_forced = 0; e_fix = 0; e_skip = 0;
        en  = !m_skip && !fix_mb && !refresh_off;
        hit = en && (m_cnt == 60);
        if (en) m_cnt = (m_cnt == 60) ? 0 : m_cnt + 1;
        mc   = !mc_disable && (int'(z) * 8 > int'(b) * 9);
        e    = mc ? b : z;
        comp = (int'(e[13:6]) < m_thr) || (v >= e);
        if (m_skip) begin
            e_skip = 1; e_inter = 1;
        end else if (fix_mb) begin
            e_fix = 1; e_inter = 1;
        end else begin
            e_forced = hit && !(ovr_en && !ovr_intra);
            if (m_fu)        e_inter = 0;
            else if (ovr_en) e_inter = !ovr_intra;
            else if (hit)    e_inter = 0;
            else             e_inter = comp;
            e_mc = mc && e_inter;
        end
    endtask

    task automatic run_mb(input logic [13:0] b, z, v, input string tag);
        logic e_mc, e_inter, e_forced, e_fix, e_skip;
        model(b, z, v, e_mc, e_inter, e_forced, e_fix, e_skip);
        @(negedge clk);
        best_err = b; zero_err = z; var_val = v;
        best_vld = 1; zero_vld = 1; var_vld = 1;
        @(negedge clk);
        best_vld = 0; zero_vld = 0; var_vld = 0;
        @(negedge clk);
        chk("R12", "valid early", int'(dec_valid), 0);
        @(negedge clk);
        chk("R12", "valid", int'(dec_valid), 1);
        chk(tag, "mc_used", int'(mc_used), int'(e_mc));
        chk(tag, "inter_mode", int'(inter_mode), int'(e_inter));
        chk(tag, "forced_intra", int'(forced_intra), int'(e_forced));
        chk(tag, "fixed_out", int'(fixed_out), int'(e_fix));
        chk(tag, "skipped_out", int'(skipped_out), int'(e_skip));
        @(negedge clk);
        chk("R12", "valid one cycle", int'(dec_valid), 0);
    endtask

    task automatic load_thr(input logic [7:0] t);
        @(negedge clk); thr_data = t; thr_load = 1;
        @(negedge clk); thr_load = 0;
        m_thr = int'(t);
    endtask

    task automatic new_frame(input logic fu, input logic sk);
        @(negedge clk); fast_upd_req = fu; skip_req = sk; frame_start = 1;
        @(negedge clk); frame_start = 0;
        m_fu = fu; m_skip = sk;
    endtask

    // plain decisions until model counter reaches target
    task automatic advance_to(input int target);
        while (m_cnt != target) run_mb(14'd100, 14'd100, 14'd4000, "R5");
    endtask

    initial begin
        void'($urandom(32'd2611));
        repeat (3) @(negedge clk);
        chk("R12", "reset dec_valid", int'(dec_valid), 0);
        chk("R12", "reset inter_mode", int'(inter_mode), 0);
        chk("R12", "reset mc_used", int'(mc_used), 0);
        rst_n = 1;
        @(negedge clk);

        // R4: reset threshold 3; bits 13:6 = 2 -> inter, = 3 with var 0 -> intra
        run_mb(14'h0BF, 14'h0BF, 14'd0, "R4");
        run_mb(14'h0C0, 14'h0C0, 14'd0, "R4");
        load_thr(8'd4);
        run_mb(14'h0C0, 14'h0C0, 14'd0, "R4");
        // R1: on-line point rejected, just beyond accepted
        run_mb(14'd8, 14'd9, 14'd0, "R1");
        run_mb(14'd8, 14'd10, 14'd0, "R1");
        run_mb(14'd800, 14'd900, 14'd0, "R1");
        // R2/R3: best chosen, variance compared against it
        run_mb(14'd1000, 14'd2000, 14'd1500, "R2");
        run_mb(14'd1000, 14'd2000, 14'd1000, "R3");
        run_mb(14'd1000, 14'd2000, 14'd999, "R3");
        run_mb(14'd2000, 14'd2000, 14'd1999, "R3");
        // R11: disable -> zero error used, 1500 < 2000 -> intra
        mc_disable = 1;
        run_mb(14'd1000, 14'd2000, 14'd1500, "R11");
        mc_disable = 0;

        // R12: strobes in EVAL/EMIT are ignored
        @(negedge clk);
        best_vld = 1; zero_vld = 1; var_vld = 1;
        best_err = 14'd10; zero_err = 14'd10; var_val = 14'd10;
        @(negedge clk); best_vld = 0; zero_vld = 0; var_vld = 0;
        @(negedge clk); best_vld = 1; zero_vld = 1; var_vld = 1;   // EVAL
        @(negedge clk);                                           // EMIT
        chk("R12", "valid after gather", int'(dec_valid), 1);
        @(negedge clk); best_vld = 0; zero_vld = 0; var_vld = 0;
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (dec_valid) seen++;
            end
            chk("R12", "ignored strobes give no decision", seen, 0);
        end
        begin
            logic a, b2, c, d, e2;
            model(14'd10, 14'd10, 14'd10, a, b2, c, d, e2);  // account for the ignored-test decision
        end

        // R5: refresh hit
        advance_to(60);
        run_mb(14'd100, 14'd100, 14'd4000, "R5");
        // R6: paused counter
        advance_to(59);
        refresh_off = 1;
        run_mb(14'd100, 14'd100, 14'd4000, "R6");
        run_mb(14'd100, 14'd100, 14'd4000, "R6");
        refresh_off = 0;
        run_mb(14'd100, 14'd100, 14'd4000, "R6");
        fix_mb = 1;
        run_mb(14'd100, 14'd100, 14'd4000, "R6");
        fix_mb = 0;
        run_mb(14'd100, 14'd100, 14'd4000, "R6");
        // R7: force inter on a hit, force intra otherwise
        advance_to(60);
        ovr_en = 1; ovr_intra = 0;
        run_mb(14'd100, 14'd100, 14'd0, "R7");
        ovr_intra = 1;
        run_mb(14'd100, 14'd100, 14'd4000, "R7");
        ovr_en = 0; ovr_intra = 0;
        // R10: fix over host force and refresh
        advance_to(60);
        fix_mb = 1; ovr_en = 1; ovr_intra = 1;
        run_mb(14'd100, 14'd200, 14'd0, "R10");
        fix_mb = 0; ovr_en = 0; ovr_intra = 0;
        // R8: fast update latched only at frame start
        @(negedge clk); fast_upd_req = 1;
        run_mb(14'd100, 14'd100, 14'd4000, "R8");
        new_frame(1'b1, 1'b0);
        run_mb(14'd100, 14'd100, 14'd4000, "R8");
        @(negedge clk); fast_upd_req = 0;
        run_mb(14'd100, 14'd100, 14'd4000, "R8");
        new_frame(1'b0, 1'b0);
        run_mb(14'd100, 14'd100, 14'd4000, "R8");
        // R9: skip beats fix
        new_frame(1'b1, 1'b1);
        fix_mb = 1;
        run_mb(14'd100, 14'd200, 14'd4000, "R9");
        fix_mb = 0;
        run_mb(14'd100, 14'd200, 14'd4000, "R9");
        new_frame(1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [13:0] b, z, v;
            if (i % 25 == 0) new_frame(($urandom % 6) == 0, ($urandom % 8) == 0);
            if (i % 30 == 7) load_thr(8'($urandom % 16));
            @(negedge clk);
            fix_mb      = ($urandom % 15) == 0;
            ovr_en      = ($urandom % 10) == 0;
            ovr_intra   = $urandom % 2;
            refresh_off = ($urandom % 20) == 0;
            mc_disable  = ($urandom % 10) == 0;
            b = 14'($urandom % 4096);
            if ($urandom % 2) z = 14'(int'(b) + int'(b) / 8 + int'($urandom % 5) - 2);
            else              z = 14'($urandom % 4096);
            v = 14'($urandom % 4096);
            run_mb(b, z, v, "R3");
        end

        finish_run();
    end

endmodule